// File: doc/BRIEF.md
# Pixel Colour Component Extractor

This block sits between a pixel fetch unit and the video output of a display pipeline. Each pixel clock it receives a fetched pixel word of one to four bytes. It produces one 8-bit red, one 8-bit green and one 8-bit blue value. A format word sets how many bytes of the pixel word are valid. Three channel select words each set, at run time, where a colour field sits in the pixel word, how wide the field is, and which value to send when the field cannot be used.

A field narrower than eight bits is placed at the top of the 8-bit output. Its upper bits are then repeated down into the lower bits, so full-scale input gives full-scale output. A channel sends its configured default value in three cases: its width is zero, the pixel lies outside the visible area, or the fetch unit reports an underrun. The block has no state machine; its only sequential logic is a two-stage pipeline. The first stage registers the byte-masked word, the decoded selects and the blanking flag. The second stage registers the three channel values.

Top module: `pix_chan_extract`

## Requirements
- R1: While `rst_n` is low, all three outputs are 0.
- R2: Each output reflects the inputs sampled at the clock edge two edges earlier: a fixed latency of two cycles, with a new pixel accepted every cycle.
- R3: In each channel select word, bits 23:16 hold the default value, bits 11:8 the bit count and bits 4:0 the index of the lowest extracted bit. Bits 31:24, 15:12 and 7:5 have no effect on the output.
- R4: A channel whose bit count is 0 outputs its default value.
- R5: When `pix_visible` is 0, all three channels output their default values.
- R6: When `pix_underrun` is 1, all three channels output their default values.
- R7: Bits 4:3 of `fmt_cfg` hold bytes-per-pixel minus one. Pixel word bits at or above bytes-per-pixel times 8 are read as zero.
- R8: An extracted field of n bits (1 to 7) fills output bits 7 down to 8-n. Each lower output bit repeats the field bit n positions above it.
- R9: A bit count from 9 to 15 behaves exactly as a count of 8.
- R10: Field bits that fall above bit 31 of the pixel word, when the index plus the count passes 32, are read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_word | input | 32 | Fetched pixel word, least significant byte first |
| pix_visible | input | 1 | High when the pixel lies inside the visible area |
| pix_underrun | input | 1 | High when the fetch unit has no data for this pixel |
| fmt_cfg | input | 32 | Format word; bits 4:3 are bytes-per-pixel minus one |
| red_cfg | input | 32 | Red channel select word |
| grn_cfg | input | 32 | Green channel select word |
| blu_cfg | input | 32 | Blue channel select word |
| red_out | output | 8 | Red channel output |
| grn_out | output | 8 | Green channel output |
| blu_out | output | 8 | Blue channel output |

## Verification
The bench builds the block with its default parameters: a four-byte pixel word and 8-bit channels. This makes every byte count from one to four selectable, and lets the field index reach past the top of the word. With 8-bit outputs, every field width from 1 to 15 can be compared with its replicated 8-bit expansion. This includes the widths that must be clamped to 8. Directed passes walk each width, byte count and blanking source. A random pass then holds the two-cycle alignment under continuously changing inputs.

// File: rtl/pce_pkg.sv
package pce_pkg;

    // Channel select word layout
    localparam int DFLT_LSB = 16;
    localparam int DFLT_W   = 8;
    localparam int CNT_LSB  = 8;
    localparam int CNT_W    = 4;
    localparam int IDX_LSB  = 0;
    localparam int IDX_W    = 5;
    localparam int CFG_W    = 32;

    // Format word layout
    localparam int FMT_LSB  = 3;

    typedef struct packed {
        logic [DFLT_W-1:0] dflt;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
    } chan_sel_t;

    function automatic chan_sel_t decode_sel(input logic [CFG_W-1:0] raw);
        chan_sel_t s;
        s.dflt = raw[DFLT_LSB +: DFLT_W];
        s.cnt  = raw[CNT_LSB  +: CNT_W];
        s.idx  = raw[IDX_LSB  +: IDX_W];
        return s;
    endfunction

endpackage

// File: rtl/pce_word_mask.sv
module pce_word_mask #(
    parameter int WORD_BYTES = 4,
    parameter int BPP_W      = 2
) (
    input  logic [WORD_BYTES*8-1:0] word_in,
    input  logic [BPP_W-1:0]        bpp_m1,
    output logic [WORD_BYTES*8-1:0] word_out
);

    // Each byte is kept only when it lies inside the configured pixel size
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
        assign word_out[b*8 +: 8] = (BPP_W'(b) <= bpp_m1) ? word_in[b*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/pce_chan_unit.sv
module pce_chan_unit
    import pce_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int OUT_W  = 8
) (
    input  logic [WORD_W-1:0] word,
    input  chan_sel_t         sel,
    input  logic              blank,
    output logic [OUT_W-1:0]  value
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(OUT_W);

    logic [CNT_W-1:0]  n_eff;
    logic [WORD_W-1:0] shifted;
    logic [OUT_W-1:0]  expanded;
    logic [CNT_W-1:0]  src;

    always_comb begin
        n_eff   = (sel.cnt > CNT_MAX) ? CNT_MAX : sel.cnt;
        shifted = word >> sel.idx;
        // Walk the output from the top, cycling through the field from its MSB
        src      = (n_eff == '0) ? '0 : n_eff - 1'b1;
        expanded = '0;
        for (int i = OUT_W - 1; i >= 0; i--) begin
            expanded[i] = shifted[src];
            if (src == '0) begin
                src = (n_eff == '0) ? '0 : n_eff - 1'b1;
            end else begin
                src = src - 1'b1;
            end
        end
        value = (blank || n_eff == '0) ? sel.dflt : expanded;
    end

endmodule

// File: rtl/pix_chan_extract.sv
module pix_chan_extract
    import pce_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int OUT_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WORD_BYTES*8-1:0] pix_word,
    input  logic                    pix_visible,
    input  logic                    pix_underrun,
    input  logic [CFG_W-1:0]        fmt_cfg,
    input  logic [CFG_W-1:0]        red_cfg,
    input  logic [CFG_W-1:0]        grn_cfg,
    input  logic [CFG_W-1:0]        blu_cfg,
    output logic [OUT_W-1:0]        red_out,
    output logic [OUT_W-1:0]        grn_out,
    output logic [OUT_W-1:0]        blu_out
);

    localparam int WORD_W = WORD_BYTES * 8;
    localparam int BPP_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam int N_CH   = 3;

    logic [WORD_W-1:0] masked_word;
    logic [CFG_W-1:0]  cfg_raw [N_CH];
    chan_sel_t         s1_sel  [N_CH];
    logic [WORD_W-1:0] s1_word;
    logic              s1_blank;
    logic [OUT_W-1:0]  ch_val  [N_CH];
    logic [OUT_W-1:0]  s2_val  [N_CH];

    assign cfg_raw[0] = red_cfg;
    assign cfg_raw[1] = grn_cfg;
    assign cfg_raw[2] = blu_cfg;

    pce_word_mask #(
        .WORD_BYTES(WORD_BYTES),
        .BPP_W     (BPP_W)
    ) u_mask (
        .word_in (pix_word),
        .bpp_m1  (fmt_cfg[FMT_LSB +: BPP_W]),
        .word_out(masked_word)
    );

    // Stage 1: masked word, decoded selects, blanking flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_word  <= '0;
            s1_blank <= 1'b0;
        end else begin
            s1_word  <= masked_word;
            s1_blank <= !pix_visible || pix_underrun;
        end
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_sel[c] <= '0;
            end else begin
                s1_sel[c] <= decode_sel(cfg_raw[c]);
            end
        end

        pce_chan_unit #(
            .WORD_W(WORD_W),
            .OUT_W (OUT_W)
        ) u_unit (
            .word (s1_word),
            .sel  (s1_sel[c]),
            .blank(s1_blank),
            .value(ch_val[c])
        );

        // Stage 2: channel output register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s2_val[c] <= '0;
            end else begin
                s2_val[c] <= ch_val[c];
            end
        end
    end

    assign red_out = s2_val[0];
    assign grn_out = s2_val[1];
    assign blu_out = s2_val[2];

endmodule

// File: rtl/pce_chk.sv
module pce_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pix_visible,
    input logic        pix_underrun,
    input logic [31:0] red_cfg,
    input logic [31:0] grn_cfg,
    input logic [31:0] blu_cfg,
    input logic [7:0]  red_out,
    input logic [7:0]  grn_out,
    input logic [7:0]  blu_out
);

    logic [1:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= 2'd0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    // R1
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            reset_zero_chk: assert (red_out == 8'h00 && grn_out == 8'h00 && blu_out == 8'h00);
        end
    end

    // R5
    invis_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && !$past(pix_visible, 2)) |->
            (red_out == $past(red_cfg[23:16], 2) && grn_out == $past(grn_cfg[23:16], 2)
             && blu_out == $past(blu_cfg[23:16], 2)));

    // R6
    underrun_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && $past(pix_underrun, 2)) |->
            (red_out == $past(red_cfg[23:16], 2) && grn_out == $past(grn_cfg[23:16], 2)
             && blu_out == $past(blu_cfg[23:16], 2)));

    // R4
    zero_cnt_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && $past(red_cfg[11:8], 2) == 4'd0) |->
            red_out == $past(red_cfg[23:16], 2));

    // R4
    zero_cnt_blu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && $past(blu_cfg[11:8], 2) == 4'd0) |->
            blu_out == $past(blu_cfg[23:16], 2));

endmodule

bind pix_chan_extract pce_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_visible (pix_visible),
    .pix_underrun(pix_underrun),
    .red_cfg     (red_cfg),
    .grn_cfg     (grn_cfg),
    .blu_cfg     (blu_cfg),
    .red_out     (red_out),
    .grn_out     (grn_out),
    .blu_out     (blu_out)
);

// File: tb/pix_chan_extract_test.sv
module pix_chan_extract_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pix_word = '0;
    logic        pix_visible = 1'b0;
    logic        pix_underrun = 1'b0;
    logic [31:0] fmt_cfg = '0;
    logic [31:0] red_cfg = '0;
    logic [31:0] grn_cfg = '0;
    logic [31:0] blu_cfg = '0;
    logic [7:0]  red_out, grn_out, blu_out;

    int checks = 0;
    int errors = 0;
    logic [23:0] q_exp[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    pix_chan_extract uut (
        .clk(clk), .rst_n(rst_n), .pix_word(pix_word), .pix_visible(pix_visible),
        .pix_underrun(pix_underrun), .fmt_cfg(fmt_cfg), .red_cfg(red_cfg),
        .grn_cfg(grn_cfg), .blu_cfg(blu_cfg), .red_out(red_out), .grn_out(grn_out),
        .blu_out(blu_out)
    );

    function automatic logic [31:0] sel(input int dflt, input int cnt, input int idx);
        return (32'(dflt & 255) << 16) | (32'(cnt & 15) << 8) | 32'(idx & 31);
    endfunction

    function automatic logic [31:0] fmt(input int bytes);
        return 32'(bytes - 1) << 3;
    endfunction

    // Behavioural model of one channel
    function automatic logic [7:0] model(input logic [31:0] word, input logic [31:0] f,
                                         input logic [31:0] c, input logic vis, input logic und);
        int bytes = int'(f[4:3]) + 1;
        int n = int'(c[11:8]);
        int idx = int'(c[4:0]);
        longint masked, field, acc;
        int filled;
        if (n > 8) n = 8;
        if (n == 0 || !vis || und) return c[23:16];
        masked = longint'(word) & ((longint'(1) << (bytes * 8)) - 1);
        field  = (masked >> idx) & ((longint'(1) << n) - 1);
        acc = 0; filled = 0;
        while (filled < 8) begin
            acc = (acc << n) | field;
            filled += n;
        end
        return 8'(acc >> (filled - 8));
    endfunction

    task automatic step(input logic [31:0] w, input logic vis, input logic und,
                        input logic [31:0] f, input logic [31:0] r, input logic [31:0] g,
                        input logic [31:0] b, input string tag);
        logic [23:0] e;
        @(negedge clk);
        if (q_exp.size() == 2) begin
            e = q_exp.pop_front();
            tag = q_tag.pop_front();
            checks++;
            if ({red_out, grn_out, blu_out} !== e) begin
                errors++;
                $display("FAIL %s: got %h expected %h", tag, {red_out, grn_out, blu_out}, e);
            end
        end
        pix_word = w; pix_visible = vis; pix_underrun = und;
        fmt_cfg = f; red_cfg = r; grn_cfg = g; blu_cfg = b;
        q_exp.push_back({model(w, f, r, vis, und), model(w, f, g, vis, und), model(w, f, b, vis, und)});
        q_tag.push_back(tag);
    endtask

    task automatic reset_check(input string tag);
        checks++;
        if ({red_out, grn_out, blu_out} !== 24'h0) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, {red_out, grn_out, blu_out}, 24'h0);
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: outputs held at zero during reset despite active inputs
        pix_word = 32'hFFFF_FFFF; pix_visible = 1'b1; fmt_cfg = fmt(4);
        red_cfg = sel(8'h12, 8, 0); grn_cfg = sel(8'h34, 8, 8); blu_cfg = sel(8'h56, 8, 16);
        repeat (3) @(negedge clk);
        reset_check("R1");
        rst_n = 1'b1;

        // R3: plain 8-bit fields, then junk in unused select bits
        step(32'h00AA_BB_CC, 1, 0, fmt(4), sel(1, 8, 16), sel(2, 8, 8), sel(3, 8, 0), "R3");
        step(32'h0011_2233, 1, 0, fmt(4), sel(1, 8, 16) | 32'hFF00_F0E0,
             sel(2, 8, 8) | 32'hA500_50A0, sel(3, 8, 0) | 32'h5A00_A0C0, "R3");
        // R4: zero count gives default
        step(32'hDEAD_BEEF, 1, 0, fmt(4), sel(8'h7F, 0, 3), sel(8'h80, 8, 0), sel(8'hC1, 0, 0), "R4");
        // R5: invisible pixel
        step(32'hDEAD_BEEF, 0, 0, fmt(4), sel(8'h11, 8, 0), sel(8'h22, 5, 5), sel(8'h33, 6, 11), "R5");
        // R6: underrun
        step(32'hCAFE_F00D, 1, 1, fmt(4), sel(8'h44, 8, 0), sel(8'h55, 5, 5), sel(8'h66, 6, 11), "R6");
        step(32'hCAFE_F00D, 0, 1, fmt(4), sel(8'h77, 8, 0), sel(8'h88, 5, 5), sel(8'h99, 6, 11), "R6");
        // R7: each byte count with all-ones word
        for (int by = 1; by <= 4; by++) begin
            step(32'hFFFF_FFFF, 1, 0, fmt(by), sel(0, 8, 24), sel(0, 8, 16), sel(0, 8, 4), "R7");
        end
        // R8: every narrow width
        for (int n = 1; n <= 7; n++) begin
            step(32'h0000_A5C3, 1, 0, fmt(2), sel(0, n, 0), sel(0, n, 3), sel(0, n, 9), "R8");
        end
        // R9: counts above 8
        for (int n = 9; n <= 15; n++) begin
            step(32'h9A5C_3E71, 1, 0, fmt(4), sel(0, n, 1), sel(0, n, 13), sel(0, n, 20), "R9");
        end
        // R10: field runs off the top of the word
        step(32'hF000_0000, 1, 0, fmt(4), sel(0, 8, 28), sel(0, 4, 30), sel(0, 3, 31), "R10");
        step(32'hFFFF_FFFF, 1, 0, fmt(4), sel(0, 8, 31), sel(0, 2, 31), sel(0, 6, 27), "R10");
        // R2: back-to-back random pixels keep two-cycle alignment
        for (int k = 0; k < 300; k++) begin
            step($urandom, ($urandom % 8) != 0, ($urandom % 10) == 0, $urandom,
                 $urandom, $urandom, $urandom, "R2");
        end
        // drain
        step('0, 0, 0, '0, '0, '0, '0, "R2");
        step('0, 0, 0, '0, '0, '0, '0, "R2");
        step('0, 0, 0, '0, '0, '0, '0, "R2");
        // R1: reset asserted mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        reset_check("R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule